// File: doc/BRIEF.md
# Masked-Write Soft Reset Register Bank

This block holds a bank of memory-mapped control registers. Every register bit drives one soft-reset output toward a peripheral block. Software asserts a peripheral's reset by writing a 1 to its bit and releases it by writing a 0. A simple synchronous register bus reaches the bank. The bus carries a byte address, a write enable, 32-bit write data and combinational 32-bit read data. Registers sit at a 4-byte stride.

A synthesis-time parameter selects one of two variants.

- **Masked variant.** Each register controls 16 lines in bits [15:0]. The upper half of each written word is a per-bit write enable for the lower half. One write can therefore set or clear any single line, and no read-modify-write is needed.
- **Plain variant.** Each register holds 32 ordinary read/write reset bits. A write replaces the whole register.

The number of outputs is the register count times the lines per register.

Top module: `rst_ctrl_bank`

## Requirements
- R1: While rst_ni is low, every soft-reset output is 0 (released) and every register reads back 0. They stay so after reset is released until a write changes them.
- R2: Masked variant: on a write, register bit n (n in 0..15) takes write-data bit n only when write-data bit n+16 is 1. Every bit whose enable is 0 keeps its previous value.
- R3: Masked variant: a single write with bits n and n+16 set asserts line n. A single write with only bit n+16 set releases it. No other line in that register changes.
- R4: Masked variant: a read returns the 16 reset bits in [15:0] and zeros in [31:16].
- R5: Plain variant: a write replaces all 32 bits of the addressed register with the write data, and a read returns all 32 bits.
- R6: Register k is at byte address 4*k, and address bits [1:0] are ignored. Output line i is bit i%L of register i/L, where L is 16 (masked) or 32 (plain).
- R7: An output changes only at the rising clock edge that accepts a write to its register, and it is visible right after that edge. Without a write, the outputs hold.
- R8: A write to a register index at or above NUM_REGS changes no output, and a read of such an address returns 0.
- R9: A write changes only the addressed register. All other registers keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| wr_en_i | input | 1 | Write strobe, accepted at the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for addr_i |
| soft_rst_o | output | NUM_REGS*L | Soft-reset lines, 1 = asserted |

## Verification
The assertions assume the following about the inputs:
- ADDR_W is at least 2 plus the bits needed to index NUM_REGS.
- wr_en_i, addr_i and wr_data_i are stable around each rising edge.
- Nothing but a bus write changes a register.

The stimulus drives every bus input on the falling edge and samples on the next falling edge. Random addresses are drawn from a window that covers every valid register, a few indices past the end, the top of the address space and nonzero low address bits. Random data is drawn over full 32-bit words, so enable patterns of every density reach the masked variant.

// File: rtl/rstb_pkg.sv
package rstb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = 16;

  function automatic int lines_per_reg(input bit masked);
    return masked ? HALF_W : DATA_W;
  endfunction

  // Lower half takes new data where the upper-half enable is set.
  function automatic logic [HALF_W-1:0] masked_merge(input logic [HALF_W-1:0] cur,
                                                     input logic [DATA_W-1:0] wd);
    return (cur & ~wd[DATA_W-1:HALF_W]) | (wd[HALF_W-1:0] & wd[DATA_W-1:HALF_W]);
  endfunction
endpackage

// File: rtl/rstb_decode.sv
module rstb_decode #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                hit_o,
  output logic [NUM_REGS-1:0] sel_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];
  assign idx_o = addr_i[ADDR_W-1:2];
  assign hit_o = 32'(idx_o) < 32'(NUM_REGS);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel_o[k] = wr_en_i && hit_o && (idx_o == IDX_W'(k));
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(sel_o)); // R9
    if (!wr_en_i) AST_IDLE_NO_SEL: assert (sel_o == '0); // R7
  end
endmodule

// File: rtl/rstb_reg.sv
module rstb_reg #(
  parameter bit MASKED = 1'b1,
  localparam int L     = rstb_pkg::lines_per_reg(MASKED)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [31:0]  wr_data_i,
  output logic [L-1:0] bits_o
);
  logic [L-1:0] bits_q;

  if (MASKED) begin : g_masked
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bits_q <= '0;
      else if (wr_i) bits_q <= rstb_pkg::masked_merge(bits_q, wr_data_i);
    end

    AST_MASK_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> ((bits_q ^ $past(bits_q)) & ~$past(wr_data_i[31:16])) == '0); // R2
    AST_MASK_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> ((bits_q ^ $past(wr_data_i[15:0])) & $past(wr_data_i[31:16])) == '0); // R3
  end else begin : g_plain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bits_q <= '0;
      else if (wr_i) bits_q <= wr_data_i[L-1:0];
    end

    AST_PLAIN_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> bits_q == $past(wr_data_i[L-1:0])); // R5
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(bits_q)); // R7

  assign bits_o = bits_q;
endmodule

// File: rtl/rstb_rdmux.sv
module rstb_rdmux #(
  parameter int NUM_REGS = 4,
  parameter int L        = 16,
  parameter int IDX_W    = 6
) (
  input  logic [NUM_REGS*L-1:0] bank_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  hit_i,
  output logic [31:0]           rd_o
);
  always_comb begin
    rd_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (hit_i && idx_i == IDX_W'(k)) rd_o[L-1:0] = bank_i[k*L +: L];
    end
  end
endmodule

// File: rtl/rst_ctrl_bank.sv
module rst_ctrl_bank #(
  parameter bit  MASKED    = 1'b1,
  parameter int  NUM_REGS  = 4,
  parameter int  ADDR_W    = 8,
  localparam int LPR       = rstb_pkg::lines_per_reg(MASKED),
  localparam int NUM_LINES = NUM_REGS * LPR
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [31:0]          wr_data_i,
  output logic [31:0]          rd_data_o,
  output logic [NUM_LINES-1:0] soft_rst_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    idx;
  logic                hit;
  logic [NUM_REGS-1:0] sel;

  rstb_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
    .addr_i(addr_i), .wr_en_i(wr_en_i), .idx_o(idx), .hit_o(hit), .sel_o(sel)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    rstb_reg #(.MASKED(MASKED)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(sel[k]),
      .wr_data_i(wr_data_i), .bits_o(soft_rst_o[k*LPR +: LPR])
    );
  end

  rstb_rdmux #(.NUM_REGS(NUM_REGS), .L(LPR), .IDX_W(IDX_W)) u_rdmux (
    .bank_i(soft_rst_o), .idx_i(idx), .hit_i(hit), .rd_o(rd_data_o)
  );

  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i[ADDR_W-1:2]) >= 32'(NUM_REGS)) |-> rd_data_o == '0); // R8
  AST_OOR_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(addr_i[ADDR_W-1:2]) >= 32'(NUM_REGS)) |=> $stable(soft_rst_o)); // R8

  if (MASKED) begin : g_upper_chk
    AST_UPPER_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[31:16] == '0); // R4
  end
endmodule

// File: tb/rst_ctrl_bank_tb_top.sv
`timescale 1ns/1ps
module rst_ctrl_bank_tb_top;
  localparam int MR = 4;
  localparam int PR = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  m_addr, p_addr;
  logic        m_we, p_we;
  logic [31:0] m_wd, p_wd, m_rd, p_rd;
  logic [MR*16-1:0] m_rst;
  logic [PR*32-1:0] p_rst;

  rst_ctrl_bank #(.MASKED(1'b1), .NUM_REGS(MR), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(m_addr), .wr_en_i(m_we),
    .wr_data_i(m_wd), .rd_data_o(m_rd), .soft_rst_o(m_rst));
  rst_ctrl_bank #(.MASKED(1'b0), .NUM_REGS(PR), .ADDR_W(8)) dut_plain_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(p_addr), .wr_en_i(p_we),
    .wr_data_i(p_wd), .rd_data_o(p_rd), .soft_rst_o(p_rst));

  logic [15:0] mm [MR];
  logic [31:0] pm [PR];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [63:0] exp_m_vec();
    logic [63:0] v;
    for (int k = 0; k < MR; k++) v[k*16 +: 16] = mm[k];
    return v;
  endfunction
  function automatic logic [95:0] exp_p_vec();
    logic [95:0] v;
    for (int k = 0; k < PR; k++) v[k*32 +: 32] = pm[k];
    return v;
  endfunction
  function automatic logic [31:0] exp_m_rd(input logic [7:0] a);
    return (int'(a[7:2]) < MR) ? {16'h0, mm[a[7:2]]} : 32'h0;
  endfunction
  function automatic logic [31:0] exp_p_rd(input logic [7:0] a);
    return (int'(a[7:2]) < PR) ? pm[a[7:2]] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_m(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); m_addr = a; m_wd = d; m_we = 1'b1;
    @(negedge clk); m_we = 1'b0;
    if (int'(a[7:2]) < MR)
      mm[a[7:2]] = (mm[a[7:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask
  task automatic wr_p(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); p_addr = a; p_wd = d; p_we = 1'b1;
    @(negedge clk); p_we = 1'b0;
    if (int'(a[7:2]) < PR) pm[a[7:2]] = d;
  endtask
  task automatic rd_m(input string req, input logic [7:0] a);
    m_addr = a; #1; check(req, 96'(m_rd), 96'(exp_m_rd(a)));
  endtask
  task automatic rd_p(input string req, input logic [7:0] a);
    p_addr = a; #1; check(req, 96'(p_rd), 96'(exp_p_rd(a)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    m_addr = '0; m_we = 0; m_wd = '0; p_addr = '0; p_we = 0; p_wd = '0;
    for (int k = 0; k < MR; k++) mm[k] = '0;
    for (int k = 0; k < PR; k++) pm[k] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 masked outputs in reset", 96'(m_rst), 96'(0));
    check("R1 plain outputs in reset", p_rst, 96'(0));
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check("R1 masked outputs after reset", 96'(m_rst), 96'(0));
    rd_m("R1 masked read 0", 8'h00);
    rd_p("R1 plain read 8", 8'h08);

    // R7: no change before the accepting edge, change right after it
    @(negedge clk); m_addr = 8'h04; m_wd = 32'h0008_0008; m_we = 1'b1;
    #3 check("R7 before edge", 96'(m_rst), 96'(0));
    @(posedge clk); #1;
    check("R7 after edge line 19", 96'(m_rst[19]), 96'(1));
    @(negedge clk); m_we = 1'b0; mm[1] = 16'h0008;
    repeat (2) @(negedge clk);
    check("R7 hold without write", 96'(m_rst), 96'(exp_m_vec()));

    // R3: release with enable only, neighbours untouched
    wr_m(8'h04, 32'h0001_0001);
    check("R3 assert line 16", 96'(m_rst[31:16]), 96'(16'h0009));
    wr_m(8'h04, 32'h0008_0000);
    check("R3 release line 19", 96'(m_rst[31:16]), 96'(16'h0001));

    // R2: only enabled bits take data
    wr_m(8'h08, 32'h00F0_FFFF);
    check("R2 partial enable", 96'(m_rst[47:32]), 96'(16'h00F0));
    wr_m(8'h08, 32'h0000_FFFF);
    check("R2 zero enable no change", 96'(m_rst), 96'(exp_m_vec()));
    wr_m(8'h08, 32'h00A0_0000);
    check("R2 clear under enable", 96'(m_rst[47:32]), 96'(16'h0050));

    // R6: line mapping and ignored low address bits
    wr_m(8'h0D, 32'h8000_8000);
    check("R6 line 63 via addr 0x0D", 96'(m_rst[63]), 96'(1));
    check("R6 full vector", 96'(m_rst), 96'(exp_m_vec()));
    rd_m("R6 read via addr 0x0E", 8'h0E);

    // R4: upper half reads zero
    wr_m(8'h00, 32'hFFFF_FFFF);
    rd_m("R4 masked upper zero", 8'h00);

    // R8: out of range
    wr_m(8'h10, 32'hFFFF_FFFF);
    check("R8 masked oor write ignored", 96'(m_rst), 96'(exp_m_vec()));
    rd_m("R8 masked oor read", 8'h10);
    rd_m("R8 masked top read", 8'hFC);

    // R5: plain full replace
    wr_p(8'h04, 32'hA5A5_0001);
    check("R5 plain write", p_rst, exp_p_vec());
    rd_p("R5 plain read", 8'h04);
    wr_p(8'h04, 32'h0000_8000);
    check("R5 plain replace", p_rst[63:32], 32'h0000_8000);
    wr_p(8'h0C, 32'hFFFF_FFFF);
    check("R8 plain oor write ignored", p_rst, exp_p_vec());
    rd_p("R8 plain oor read", 8'h0C);

    // R9 and random coverage
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = ($urandom % 16 == 0) ? 8'hFC : 8'($urandom % ((MR + 2) * 4));
      d = $urandom;
      wr_m(a, d);
      check("R9 masked random vector", 96'(m_rst), 96'(exp_m_vec()));
      rd_m("R4 masked random read", 8'($urandom % ((MR + 2) * 4)));
    end
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      a = ($urandom % 16 == 0) ? 8'hFC : 8'($urandom % ((PR + 2) * 4));
      wr_p(a, $urandom);
      check("R9 plain random vector", p_rst, exp_p_vec());
      rd_p("R5 plain random read", 8'($urandom % ((PR + 2) * 4)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule